// File: doc/BRIEF.md
# MAC Error Event Latch and Interrupt Mask

This block gathers seventeen single-cycle event pulses raised by the error and status logic around a 10-gigabit Ethernet MAC. Each pulse sets a sticky bit in an event register. A bit stays set until software clears it by writing a one to that bit position. A mask register of the same layout selects which latched events may raise the interrupt. The single level interrupt output is the registered OR of every latched event whose mask bit is set.

Software reaches both registers through a plain 32-bit register port. The port has a write strobe, a byte address, write data and read data. Read data is combinational from the address, and reads have no side effects. There is no streaming data path, so the port has no valid/ready handshake. A write strobe is accepted in every cycle and takes effect at the next clock edge. The mask register sits at offset 0x00 and the event register at offset 0x04. Other offsets read as zero.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the mask register and the event register both read 0, and `irq` is 0.
- R2: A pulse on `src_pulse[i]` sets event bit i at the next clock edge. The bit map is: 16 MDIO scan, 15 MDIO command complete, 14 remote fault, 13 local fault, 12 TX ECC error, 11 TX FIFO underflow, 10 TX FIFO overflow, 9 TX error, 8 RX FIFO overflow, 7 RX ECC error, 6 jabber, 5 oversize, 4 runt, 3 fragment, 2 length error, 1 CRC error, 0 alignment error.
- R3: A set event bit stays set through any number of cycles without a write to offset 0x04.
- R4: A write to offset 0x04 clears each event bit whose write-data bit is 1. Bits written as 0 are unchanged. Writing 0xFFFFFFFF clears every event bit.
- R5: If a source pulse and a clearing write reach the same event bit in the same cycle, the bit is set after that edge.
- R6: A write to offset 0x00 loads bits 16..0 of the mask, and the mask reads back exactly that value. An example is 0x00017FFB, which is every source except bits 15 and 2. A mask write leaves the event register unchanged.
- R7: Bits 31..17 of both registers always read as 0, and writes to those bits have no effect.
- R8: `irq` equals the OR over bits 16..0 of (event AND mask), delayed by one clock. It therefore rises one edge after the event bit is latched, and falls one edge after the clear.
- R9: An event whose mask bit is 0 is still latched and readable, but it does not assert `irq`.
- R10: Writes to any offset other than 0x00 and 0x04 change no state, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 17 | One event pulse per source, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check four properties:
- a source pulse always leaves its event bit set, which covers the case where a clear write lands in the same cycle;
- event bits never drop without a write to the event offset;
- a clear write removes exactly the requested bits that had no new pulse;
- the mask takes the written value, the upper read bits stay zero, and `irq` follows the gated OR of the previous cycle.

The bench scenarios are needed for the rest: the one-to-one map from source to bit position, ignored writes to unmapped offsets, and a masked event that stays readable while the interrupt stays low. Random mixes of pulses and writes, compared each cycle against a reference model, exercise overlaps that the directed cases do not reach.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EVT_COUNT = 17;

  localparam int EVB_ALIGN      = 0;
  localparam int EVB_CRC        = 1;
  localparam int EVB_LENGTH     = 2;
  localparam int EVB_FRAGMENT   = 3;
  localparam int EVB_RUNT       = 4;
  localparam int EVB_OVERSIZE   = 5;
  localparam int EVB_JABBER     = 6;
  localparam int EVB_RX_ECC     = 7;
  localparam int EVB_RX_OVFL    = 8;
  localparam int EVB_TX_ERR     = 9;
  localparam int EVB_TX_OVFL    = 10;
  localparam int EVB_TX_UNFL    = 11;
  localparam int EVB_TX_ECC     = 12;
  localparam int EVB_LOCAL_FLT  = 13;
  localparam int EVB_REMOTE_FLT = 14;
  localparam int EVB_MDIO_DONE  = 15;
  localparam int EVB_MDIO_SCAN  = 16;

  // Suggested enable set: everything except MDIO done and length error
  localparam logic [EVT_COUNT-1:0] EVT_SUGGESTED_EN =
    ~((EVT_COUNT'(1) << EVB_MDIO_DONE) | (EVT_COUNT'(1) << EVB_LENGTH));
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);
  // One flop per source; a new pulse takes precedence over a clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o[i] <= 1'b0;
      else        state_o[i] <= set_i[i] | (state_o[i] & ~clr_i[i]);
    end
  end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] value_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_o <= '0;
    else if (load_i) mask_o <= value_i;
  end
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
  parameter int N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] live;

  assign live = ev_i & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |live;
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port #(
  parameter int N         = 17,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_OFS  = 0,
  parameter int EVENT_OFS = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      ev_i,
  input  logic [N-1:0]      mask_i,
  output logic              mask_load_o,
  output logic [N-1:0]      mask_val_o,
  output logic [N-1:0]      ev_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] EVENT_A = ADDR_W'(EVENT_OFS);

  logic hit_mask, hit_event;
  logic unused_hi_bits;

  assign hit_mask       = (addr_i == MASK_A);
  assign hit_event      = (addr_i == EVENT_A);
  assign unused_hi_bits = ^wdata_i[DATA_W-1:N];

  always_comb begin
    mask_load_o = wr_i && hit_mask;
    mask_val_o  = wdata_i[N-1:0];
    ev_clr_o    = (wr_i && hit_event) ? wdata_i[N-1:0] : '0;
    rdata_o     = '0;
    if (hit_mask)       rdata_o[N-1:0] = mask_i;
    else if (hit_event) rdata_o[N-1:0] = ev_i;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NUM_SRC   = evt_pkg::EVT_COUNT,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_OFS  = 0,
  parameter int EVENT_OFS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  logic [NUM_SRC-1:0] ev_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] ev_clr;
  logic [NUM_SRC-1:0] mask_val;
  logic               mask_load;

  evt_reg_port #(
    .N(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MASK_OFS(MASK_OFS), .EVENT_OFS(EVENT_OFS)
  ) u_port (
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .ev_i(ev_q), .mask_i(mask_q),
    .mask_load_o(mask_load), .mask_val_o(mask_val),
    .ev_clr_o(ev_clr), .rdata_o(reg_rdata)
  );

  evt_sticky_bank #(.N(NUM_SRC)) u_events (
    .clk(clk), .rst_n(rst_n), .set_i(src_pulse), .clr_i(ev_clr), .state_o(ev_q)
  );

  evt_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(mask_load), .value_i(mask_val), .mask_o(mask_q)
  );

  evt_irq_gate #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_q), .en_i(mask_q), .irq_o(irq)
  );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SRC   = 17,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_OFS  = 0,
  parameter int EVENT_OFS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_pulse,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq,
  input logic [NUM_SRC-1:0] ev_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic ev_wr, mk_wr;
  assign ev_wr = reg_wr && (reg_addr == ADDR_W'(EVENT_OFS));
  assign mk_wr = reg_wr && (reg_addr == ADDR_W'(MASK_OFS));

  // R2 R5
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((ev_q & $past(src_pulse)) == $past(src_pulse)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> ((ev_q & $past(reg_wdata[NUM_SRC-1:0] & ~src_pulse)) == '0));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mk_wr |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0])));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_SRC] == '0);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(ev_q & mask_q))));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .MASK_OFS(MASK_OFS), .EVENT_OFS(EVENT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .ev_q(ev_q), .mask_q(mask_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] src_pulse = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [16:0] m_ev = '0;
  logic [16:0] m_mask = '0;
  logic        m_irq = 1'b0;

  localparam logic [7:0] A_MASK = 8'h00;
  localparam logic [7:0] A_EV   = 8'h04;

  always #4 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == A_MASK) return {15'b0, m_mask};
    if (a == A_EV)   return {15'b0, m_ev};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with given stimulus; model updated with pre-edge state
  task automatic step(input logic [16:0] s, input logic w, input logic [7:0] a,
                      input logic [31:0] d);
    logic [16:0] clr;
    @(negedge clk);
    src_pulse = s; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    clr   = (w && a == A_EV) ? d[16:0] : 17'h0;
    m_irq = |(m_ev & m_mask);
    m_ev  = s | (m_ev & ~clr);
    if (w && a == A_MASK) m_mask = d[16:0];
    #1;
    chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, A_MASK, '0);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    @(negedge clk);
    src_pulse = '0; reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(req, reg_rdata, exp_read(a));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #20;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd("R1 mask", A_MASK);
    rd("R1 event", A_EV);
    @(negedge clk); rst_n = 1'b1;
    rd("R1 event after release", A_EV);

    // R2 bit map, one source at a time, then clear all (R4)
    for (int i = 0; i < 17; i++) begin
      step(17'(1) << i, 1'b0, A_MASK, '0);
      rd("R2 single source", A_EV);
      step('0, 1'b1, A_EV, 32'hFFFF_FFFF);
      rd("R4 clear all", A_EV);
    end

    // R3 sticky over idle cycles
    step(17'h10040, 1'b0, A_MASK, '0);
    idle(6);
    rd("R3 sticky", A_EV);

    // R4 partial clear
    step(17'h00003, 1'b0, A_MASK, '0);
    step('0, 1'b1, A_EV, 32'h0000_0001);
    rd("R4 partial clear", A_EV);

    // R5 set wins over same-cycle clear
    step(17'h00020, 1'b1, A_EV, 32'h0000_0020);
    rd("R5 set wins", A_EV);
    chk("R5 bit5", {31'b0, reg_rdata[5]}, 32'h1);

    // R7 upper bits ignored
    step('0, 1'b1, A_MASK, 32'hFFFF_FFFF);
    rd("R7 mask upper zero", A_MASK);
    step('0, 1'b1, A_EV, 32'hFFFE_0000);
    rd("R7 event upper write ignored", A_EV);

    // R6 mask readback and no effect on events
    step('0, 1'b1, A_EV, 32'hFFFF_FFFF);
    step('0, 1'b1, A_MASK, 32'h0001_7FFB);
    rd("R6 mask readback", A_MASK);
    chk("R6 suggested value", reg_rdata, 32'h0001_7FFB);
    rd("R6 events untouched", A_EV);

    // R9 masked source latches but no irq
    step(17'(1) << 15, 1'b0, A_MASK, '0);
    step('0, 1'b0, A_MASK, '0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    rd("R9 latched", A_EV);
    step(17'(1) << 2, 1'b0, A_MASK, '0);
    idle(2);
    chk("R9 irq low len", {31'b0, irq}, 32'h0);

    // R8 enabled source raises irq, clear drops it
    step(17'(1) << 14, 1'b0, A_MASK, '0);
    chk("R8 not yet", {31'b0, irq}, 32'h0);
    step('0, 1'b0, A_MASK, '0);
    chk("R8 raised", {31'b0, irq}, 32'h1);
    step('0, 1'b1, A_EV, 32'h0000_4000);
    step('0, 1'b0, A_MASK, '0);
    chk("R8 dropped", {31'b0, irq}, 32'h0);

    // R10 unmapped offsets
    step('0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    rd("R10 read unmapped", 8'h08);
    rd("R10 mask unchanged", A_MASK);
    rd("R10 event unchanged", A_EV);

    // Random mix against the model
    for (int k = 0; k < 600; k++) begin
      logic [16:0] s;
      logic [31:0] d;
      logic [7:0]  a;
      int op;
      s  = 17'($urandom & $urandom & $urandom);
      d  = $urandom;
      op = int'($urandom % 4);
      a  = (op == 0) ? A_MASK : (op == 1) ? A_EV : 8'h0C;
      step(s, op != 3, a, d);
      rd("R2 R4 R5 random event", A_EV);
      if (k % 8 == 0) rd("R6 random mask", A_MASK);
    end

    finish_run();
  end
endmodule